// File: doc/BRIEF.md
# MDIO Management Master

This block runs register transactions on a two-wire PHY management bus. It drives the management clock, MDC, and a data line that can be released, split into an output value, an output enable and a sampled input. A host asks for a transaction with a one-cycle strobe and a read/write select, giving a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block then sends the whole frame: a preamble of ones, the start and opcode pairs, both addresses, the turnaround and the data field. For a read it returns the 16-bit register contents.

The MDC half-period is a parameter counted in system clocks, and MDC rests low between transactions. A read whose PHY leaves the line high during the second turnaround cycle is treated as having no responder. The master clocks the bus idle for a further stretch with the line released, then reports an error flag and returns no data. A start strobe that arrives while a transaction is in flight has no effect.

Top module: `mdio_mgr`

## Requirements
- R1: Each frame opens with 32 MDC cycles in which the master drives the data line to 1 (output enable high).
- R2: After the preamble the master drives the start pair 0 then 1, then the opcode pair: 1,0 when `rd_wr`=1 (read) and 0,1 when `rd_wr`=0 (write).
- R3: Next come the 5 PHY address bits and then the 5 register address bits, each most significant bit first, one bit per MDC cycle.
- R4: MDC stays low and then high for HALF_DIV system clocks each. `mdio_o` and `mdio_oe` change only at the clock edge where MDC falls, or while MDC is low, and hold steady through every high phase.
- R5: On a read the master releases the line (`mdio_oe`=0) for both turnaround cycles and for the 16 data cycles. It samples the line during each high phase, with the most significant bit first, and presents the 16-bit result on `rd_data` when `done` pulses.
- R6: On a write the master drives the turnaround as 1 then 0, then the 16 bits of `wr_data` with the most significant bit first. It releases the line for the final MDC cycle.
- R7: A completed frame is 65 MDC cycles long, one of them a trailing cycle after the data field. `done` rises 130·HALF_DIV system clocks after the clock edge that accepted the start.
- R8: On a read, if the line is sampled high in the second turnaround cycle, the master gives 32 more MDC cycles with the line released, for 80 MDC cycles in all, with `done` at 160·HALF_DIV clocks. It then sets `ta_err` and leaves `rd_data` unchanged.
- R9: `done` is high for exactly one system clock. `busy` is high from the clock after the accepted start until the cycle in which `done` is high, and is low in that cycle.
- R10: A start strobe while `busy` is high is ignored. The frame in flight keeps its address, opcode and data, and no extra `done` occurs.
- R11: `ta_err` keeps its value after a transaction ends and is cleared when the next start is accepted.
- R12: After reset, and whenever no transaction is active, MDC is low and `mdio_oe` is 0. After reset `busy`, `done`, `ta_err` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_wr | input | 1 | 1 = register read, 0 = register write |
| phy_addr | input | 5 | PHY address for the frame |
| reg_addr | input | 5 | Register address for the frame |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Result of the last successful read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| ta_err | output | 1 | Last read saw no turnaround response |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Sampled level of the data line |

## Verification
Several properties hold on every cycle: the data line stays stable while MDC is high, MDC rests low when idle, `done` lasts one cycle and never comes while busy, and the line stays released through read turnarounds and the whole error tail. They also confirm that a strobe during a transaction leaves the latched frame fields alone. Only the scenarios, using a PHY model that answers or stays silent, can show the order of the frame bits, the round trip of read data, the exact frame lengths, the half-period and the stickiness of the error flag across idle time.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_ABORT = 2'd2
   } mm_state_e;

   // two-bit patterns sent first bit = [1]
   localparam logic [1:0] START_PAT = 2'b01;
   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] TURN_WR   = 2'b10;

endpackage

// File: rtl/mdio_mgr_clkgen.sv
module mdio_mgr_clkgen #(
   parameter int HALF_DIV    = 4,
   parameter bit SAMPLE_LATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic end_hi,
   output logic samp_ev
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          mdc_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (at_last) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mdc    = mdc_q;
   assign end_hi = run & mdc_q & at_last;

   generate
      if (SAMPLE_LATE) begin : g_late
         // sample in the final system clock of the high phase
         assign samp_ev = run & mdc_q & at_last;
      end else begin : g_early
         // sample in the first system clock after MDC rises
         assign samp_ev = run & mdc_q & (cnt_q == '0);
      end
   endgenerate

   AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mdc_q); // R12

   AST_RUN_EDGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> !mdc_q); // R4

endmodule

// File: rtl/mdio_mgr_framer.sv
module mdio_mgr_framer
   import mdio_mgr_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int PHY_AW  = 5,
   parameter int REG_AW  = 5,
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 7
) (
   input  logic [CNT_W-1:0]  idx,
   input  logic              rd,
   input  logic [PHY_AW-1:0] pa,
   input  logic [REG_AW-1:0] ra,
   input  logic [DATA_W-1:0] wd,
   output logic              oe,
   output logic              o
);
   localparam int IDX_ST  = PRE_LEN;
   localparam int IDX_OP  = IDX_ST + 2;
   localparam int IDX_PA  = IDX_OP + 2;
   localparam int IDX_RA  = IDX_PA + PHY_AW;
   localparam int IDX_TA  = IDX_RA + REG_AW;
   localparam int IDX_DAT = IDX_TA + 2;
   localparam int IDX_END = IDX_DAT + DATA_W;

   int                i;
   logic [1:0]        opc;
   logic [PHY_AW-1:0] pa_sh;
   logic [REG_AW-1:0] ra_sh;
   logic [DATA_W-1:0] wd_sh;

   always_comb begin
      i     = int'(idx);
      opc   = rd ? OPC_READ : OPC_WRITE;
      pa_sh = pa << (i - IDX_PA);
      ra_sh = ra << (i - IDX_RA);
      wd_sh = wd << (i - IDX_DAT);
      oe    = 1'b0;
      o     = 1'b0;
      if (i < IDX_ST) begin
         oe = 1'b1;
         o  = 1'b1;
      end else if (i < IDX_OP) begin
         oe = 1'b1;
         o  = (i == IDX_ST) ? START_PAT[1] : START_PAT[0];
      end else if (i < IDX_PA) begin
         oe = 1'b1;
         o  = (i == IDX_OP) ? opc[1] : opc[0];
      end else if (i < IDX_RA) begin
         oe = 1'b1;
         o  = pa_sh[PHY_AW-1];
      end else if (i < IDX_TA) begin
         oe = 1'b1;
         o  = ra_sh[REG_AW-1];
      end else if (i < IDX_DAT) begin
         if (!rd) begin
            oe = 1'b1;
            o  = (i == IDX_TA) ? TURN_WR[1] : TURN_WR[0];
         end
      end else if (i < IDX_END) begin
         if (!rd) begin
            oe = 1'b1;
            o  = wd_sh[DATA_W-1];
         end
      end
   end

endmodule

// File: rtl/mdio_mgr_seq.sv
module mdio_mgr_seq
   import mdio_mgr_pkg::*;
#(
   parameter int PRE_LEN   = 32,
   parameter int ABORT_LEN = 32,
   parameter int PHY_AW    = 5,
   parameter int REG_AW    = 5,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_wr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              end_hi,
   input  logic              samp_ev,
   input  logic              mdio_i,
   output logic              run,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy,
   output logic              ta_err
);
   localparam int IDX_TA   = PRE_LEN + 4 + PHY_AW + REG_AW;
   localparam int IDX_DAT  = IDX_TA + 2;
   localparam int IDX_TAIL = IDX_DAT + DATA_W;
   localparam int MAX_IDX  = (IDX_TAIL > ABORT_LEN) ? IDX_TAIL : ABORT_LEN;
   localparam int CNT_W    = $clog2(MAX_IDX + 1);

   localparam logic [CNT_W-1:0] C_TA2  = CNT_W'(IDX_TA + 1);
   localparam logic [CNT_W-1:0] C_TA1  = CNT_W'(IDX_TA);
   localparam logic [CNT_W-1:0] C_DAT  = CNT_W'(IDX_DAT);
   localparam logic [CNT_W-1:0] C_TAIL = CNT_W'(IDX_TAIL);
   localparam logic [CNT_W-1:0] C_ABT  = CNT_W'(ABORT_LEN - 1);

   mm_state_e         st_q;
   logic [CNT_W-1:0]  cyc_q;
   logic              rd_q;
   logic [PHY_AW-1:0] pa_q;
   logic [REG_AW-1:0] ra_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] sh_q;
   logic              samp_q;
   logic              cur_bit;
   logic              idle;

   logic [CNT_W-1:0]  fr_idx;
   logic              fr_rd;
   logic [PHY_AW-1:0] fr_pa;
   logic [REG_AW-1:0] fr_ra;
   logic [DATA_W-1:0] fr_wd;
   logic              fr_oe;
   logic              fr_o;

   assign idle    = (st_q == ST_IDLE);
   assign run     = ~idle;
   assign busy    = ~idle;
   // late sampling coincides with end_hi, so the live input is used then
   assign cur_bit = samp_ev ? mdio_i : samp_q;

   always_comb begin
      fr_idx = idle ? '0 : cyc_q + 1'b1;
      fr_rd  = idle ? rd_wr    : rd_q;
      fr_pa  = idle ? phy_addr : pa_q;
      fr_ra  = idle ? reg_addr : ra_q;
      fr_wd  = idle ? wr_data  : wd_q;
   end

   mdio_mgr_framer #(
      .PRE_LEN (PRE_LEN),
      .PHY_AW  (PHY_AW),
      .REG_AW  (REG_AW),
      .DATA_W  (DATA_W),
      .CNT_W   (CNT_W)
   ) u_framer (
      .idx (fr_idx),
      .rd  (fr_rd),
      .pa  (fr_pa),
      .ra  (fr_ra),
      .wd  (fr_wd),
      .oe  (fr_oe),
      .o   (fr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cyc_q   <= '0;
         rd_q    <= 1'b0;
         pa_q    <= '0;
         ra_q    <= '0;
         wd_q    <= '0;
         sh_q    <= '0;
         samp_q  <= 1'b0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
         rd_data <= '0;
         done    <= 1'b0;
         ta_err  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (samp_ev) samp_q <= mdio_i;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q    <= ST_FRAME;
                  cyc_q   <= '0;
                  rd_q    <= rd_wr;
                  pa_q    <= phy_addr;
                  ra_q    <= reg_addr;
                  wd_q    <= wr_data;
                  mdio_oe <= fr_oe;
                  mdio_o  <= fr_o;
                  ta_err  <= 1'b0;
               end
            end
            ST_FRAME: begin
               if (end_hi) begin
                  if (rd_q && (cyc_q == C_TA2) && cur_bit) begin
                     st_q    <= ST_ABORT;
                     cyc_q   <= '0;
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b0;
                  end else if (cyc_q == C_TAIL) begin
                     st_q    <= ST_IDLE;
                     done    <= 1'b1;
                     mdio_oe <= 1'b0;
                     mdio_o  <= 1'b0;
                     if (rd_q) rd_data <= sh_q;
                  end else begin
                     if (rd_q && (cyc_q >= C_DAT))
                        sh_q <= {sh_q[DATA_W-2:0], cur_bit};
                     cyc_q   <= cyc_q + 1'b1;
                     mdio_oe <= fr_oe;
                     mdio_o  <= fr_o;
                  end
               end
            end
            ST_ABORT: begin
               if (end_hi) begin
                  if (cyc_q == C_ABT) begin
                     st_q   <= ST_IDLE;
                     done   <= 1'b1;
                     ta_err <= 1'b1;
                  end else begin
                     cyc_q <= cyc_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(rd_q) && $stable(pa_q) && $stable(ra_q) && $stable(wd_q))); // R10

   AST_ABORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_ABORT) |-> !mdio_oe); // R8

   AST_ERR_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ta_err |-> rd_q); // R8

   AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_FRAME) && rd_q && ((cyc_q == C_TA1) || (cyc_q == C_TA2))) |-> !mdio_oe); // R5

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> !mdio_oe); // R12

endmodule

// File: rtl/mdio_mgr.sv
module mdio_mgr #(
   parameter int HALF_DIV    = 4,
   parameter bit SAMPLE_LATE = 1'b1,
   parameter int PRE_LEN     = 32,
   parameter int ABORT_LEN   = 32,
   parameter int PHY_AW      = 5,
   parameter int REG_AW      = 5,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd_wr,
   input  logic [PHY_AW-1:0] phy_addr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy,
   output logic              ta_err,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   generate
      if (HALF_DIV < 1) begin : g_bad_half
         $error("HALF_DIV must be at least 1");
      end
      if (PRE_LEN < 1 || ABORT_LEN < 1) begin : g_bad_len
         $error("PRE_LEN and ABORT_LEN must be positive");
      end
      if (PHY_AW < 1 || REG_AW < 1 || DATA_W < 2) begin : g_bad_width
         $error("address and data widths out of range");
      end
   endgenerate

   logic run;
   logic end_hi;
   logic samp_ev;

   mdio_mgr_clkgen #(
      .HALF_DIV    (HALF_DIV),
      .SAMPLE_LATE (SAMPLE_LATE)
   ) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .mdc     (mdc),
      .end_hi  (end_hi),
      .samp_ev (samp_ev)
   );

   mdio_mgr_seq #(
      .PRE_LEN   (PRE_LEN),
      .ABORT_LEN (ABORT_LEN),
      .PHY_AW    (PHY_AW),
      .REG_AW    (REG_AW),
      .DATA_W    (DATA_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd_wr    (rd_wr),
      .phy_addr (phy_addr),
      .reg_addr (reg_addr),
      .wr_data  (wr_data),
      .end_hi   (end_hi),
      .samp_ev  (samp_ev),
      .mdio_i   (mdio_i),
      .run      (run),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_data  (rd_data),
      .done     (done),
      .busy     (busy),
      .ta_err   (ta_err)
   );

   AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R4

   AST_BUSY_WITH_MDC: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> busy); // R12

endmodule

// File: tb/mdio_mgr_test.sv
`timescale 1ns/1ps
module mdio_mgr_test;
   localparam int H = 3;

   typedef struct {
      logic        rd;
      logic [4:0]  pa;
      logic [4:0]  ra;
      logic [15:0] wd;
      logic [15:0] rdv;
      logic        err;
      int          len;
      int          rises;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic rd_wr = 1'b0;
   logic [4:0] phy_addr = '0;
   logic [4:0] reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic done, busy, ta_err, mdc, mdio_o, mdio_oe;
   logic mdio_i = 1'b1;

   int tests = 0;
   int fails = 0;
   int cyc_cnt = 0;
   int t0 = 0;
   int pcyc = 0;
   int rises = 0;
   int rt0 = 0;
   int rt1 = 0;
   logic xact_done = 1'b0;
   logic phy_rd = 1'b0;
   logic phy_ta = 1'b0;
   logic [15:0] phy_data = '0;
   logic [15:0] last_rd = '0;
   logic [1:0] cap [0:127];
   exp_t q[$];
   exp_t e;

   always #4 clk = ~clk;
   always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

   mdio_mgr #(.HALF_DIV(H)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_wr(rd_wr),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .rd_data(rd_data), .done(done), .busy(busy), .ta_err(ta_err),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   // PHY model: record master bits on rising MDC, answer after falling MDC
   always @(posedge mdc) begin
      if (pcyc < 128) cap[pcyc] = {mdio_oe, mdio_o};
      if (rises == 0) rt0 = cyc_cnt;
      if (rises == 1) rt1 = cyc_cnt;
      rises++;
   end

   always @(negedge mdc) begin
      logic [15:0] t;
      pcyc++;
      #1;
      if (phy_rd && pcyc == 47) mdio_i = phy_ta;
      else if (phy_rd && pcyc >= 48 && pcyc <= 63) begin
         t = phy_data << (pcyc - 48);
         mdio_i = t[15];
      end else mdio_i = 1'b1;
   end

   function automatic logic [1:0] exp_bit(input exp_t x, input int k);
      logic [4:0]  s5;
      logic [15:0] s16;
      if (k < 32) return 2'b11;
      if (k == 32) return 2'b10;
      if (k == 33) return 2'b11;
      if (k == 34) return {1'b1, x.rd};
      if (k == 35) return {1'b1, ~x.rd};
      if (k <= 40) begin s5 = x.pa >> (40 - k); return {1'b1, s5[0]}; end
      if (k <= 45) begin s5 = x.ra >> (45 - k); return {1'b1, s5[0]}; end
      if (k <= 47) return x.rd ? 2'b00 : ((k == 46) ? 2'b11 : 2'b10);
      if (k <= 63) begin
         if (x.rd) return 2'b00;
         s16 = x.wd >> (63 - k);
         return {1'b1, s16[0]};
      end
      return 2'b00;
   endfunction

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10 unexpected done", 32'd1, 32'd0);
         end else begin
            logic bad1, bad2, bad3, bad5, bad6, bad8;
            logic [1:0] ex;
            e = q.pop_front();
            bad1 = 0; bad2 = 0; bad3 = 0; bad5 = 0; bad6 = 0; bad8 = 0;
            for (int k = 0; k < e.rises; k++) begin
               ex = exp_bit(e, k);
               if ((ex[1] == 1'b0) ? (cap[k][1] != 1'b0) : (cap[k] != ex)) begin
                  if (k < 32) bad1 = 1;
                  else if (k < 36) bad2 = 1;
                  else if (k < 46) bad3 = 1;
                  else if (k < 64) begin if (e.rd) bad5 = 1; else bad6 = 1; end
                  else if (k == 64) bad6 = 1;
                  else bad8 = 1;
               end
            end
            chk(!bad1, "R1 preamble", {31'd0, bad1}, 32'd0);
            chk(!bad2, "R2 start/opcode", {31'd0, bad2}, 32'd0);
            chk(!bad3, "R3 addresses", {31'd0, bad3}, 32'd0);
            if (e.rd) chk(!bad5, "R5 read release", {31'd0, bad5}, 32'd0);
            else      chk(!bad6, "R6 write turnaround/data", {31'd0, bad6}, 32'd0);
            if (e.err) chk(!bad8, "R8 abort released", {31'd0, bad8}, 32'd0);
            chk((cyc_cnt - t0) == e.len, e.err ? "R8 abort length" : "R7 frame length",
                cyc_cnt - t0, e.len);
            chk(rises == e.rises, "R7 MDC cycle count", rises, e.rises);
            chk(rt1 - rt0 == 2 * H, "R4 MDC period", rt1 - rt0, 2 * H);
            chk(rd_data == e.rdv, e.rd ? (e.err ? "R8 rd_data kept" : "R5 rd_data") : "R6 rd_data kept",
                {16'd0, rd_data}, {16'd0, e.rdv});
            chk(ta_err == e.err, "R8 ta_err", {31'd0, ta_err}, {31'd0, e.err});
            chk(!busy, "R9 busy low at done", {31'd0, busy}, 32'd0);
         end
         xact_done = 1'b1;
      end
   end

   task automatic xact(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic bad_ta, input logic [15:0] rv,
                       input logic intrude);
      exp_t x;
      x.rd = rd; x.pa = pa; x.ra = ra; x.wd = wd;
      x.err = rd & bad_ta;
      if (rd && !bad_ta) last_rd = rv;
      x.rdv = last_rd;
      x.len = x.err ? 160 * H : 130 * H;
      x.rises = x.err ? 80 : 65;
      q.push_back(x);
      phy_rd = rd; phy_ta = bad_ta; phy_data = rv;
      pcyc = 0; rises = 0;
      @(negedge clk);
      start = 1'b1; rd_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
      @(negedge clk);
      start = 1'b0;
      t0 = cyc_cnt;
      chk(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
      chk(ta_err == 1'b0, "R11 ta_err cleared on start", {31'd0, ta_err}, 32'd0);
      if (intrude) begin
         repeat (100) @(negedge clk);
         start = 1'b1; rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
         @(negedge clk);
         start = 1'b0;
         chk(busy == 1'b1, "R10 busy kept", {31'd0, busy}, 32'd1);
      end
      while (!xact_done) @(negedge clk);
      xact_done = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", {31'd0, done}, 32'd0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R12 idle MDC low, released",
          {30'd0, mdc, mdio_oe}, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(mdc == 0 && mdio_oe == 0 && busy == 0 && done == 0 && ta_err == 0 && rd_data == 0,
          "R12 reset state", {26'd0, mdc, mdio_oe, busy, done, ta_err, |rd_data}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      xact(1'b0, 5'h13, 5'h0A, 16'hA5C3, 1'b0, 16'h0000, 1'b0);
      xact(1'b1, 5'h01, 5'h02, 16'h0000, 1'b0, 16'h8001, 1'b0);
      xact(1'b1, 5'h1F, 5'h1F, 16'h0000, 1'b0, 16'h7FFE, 1'b0);
      xact(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0, 16'h0000, 1'b1); // R10 intruding start
      xact(1'b1, 5'h0C, 5'h15, 16'h0000, 1'b1, 16'h1234, 1'b0); // R8 no responder
      repeat (20) @(negedge clk);
      chk(ta_err == 1'b1, "R11 ta_err held while idle", {31'd0, ta_err}, 32'd1);
      chk(mdc == 1'b0, "R12 MDC low while idle", {31'd0, mdc}, 32'd0);
      xact(1'b1, 5'h0A, 5'h05, 16'h0000, 1'b0, 16'hF00F, 1'b0);
      xact(1'b0, 5'h15, 5'h11, 16'hFFFF, 1'b0, 16'h0000, 1'b0);
      repeat (50) @(negedge clk);
      chk(q.size() == 0, "R10 no extra transactions", q.size(), 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule